// File: doc/BRIEF.md
# Byte-wide SPI Port (master or slave)

This block is a serial peripheral port that moves one byte at a time through a single shift register. Transmit and receive share that register. The host writes a byte to start or preload a transfer. It reads the received byte from a holding buffer and watches a few status flags. A four-bit mode field selects the role and, for a master, the clock rate.

As a master, the port divides the system clock down to the serial clock. The clock polarity, the clock edge and the sample point can each be chosen.

As a slave, the port follows an external serial clock. That clock is oversampled through a short synchronizer. It can optionally be gated by an active-low select input.

A sleep input has different effects in the two roles:
- In master mode it freezes the serial clock and the shift state in the middle of a byte. The byte then carries on from that point once sleep is released.
- In slave mode it has no effect, so bytes keep arriving. A completed byte raises a wake request when the interrupt is enabled.

The system clock keeps running during sleep. Sleep here is a freeze request to the master logic, not a stopped clock.

Top module: `spi_port`

## Requirements
- R1: A master byte is started by a host write while idle. It makes exactly 16 serial clock transitions, shifts most-significant bit first and leaves `sck_o` at the `cpol` level when idle. The byte received on `sdi` then appears on `rd_data` and `irq_flag` rises.
- R2: Clock phase is the inverse of `cke`. With `cke`=1, data is captured on the edge leaving the idle level and changed on the edge returning to it. With `cke`=0 the two edges swap roles. So standard mode 0 is `cpol`=0,`cke`=1, mode 1 is 0,0, mode 2 is 1,1 and mode 3 is 1,0.
- R3: In master mode, `smp`=0 captures `sdi` in the middle of each bit's output time. `smp`=1 captures it at the end of that time, which is the edge on which the next bit is driven. With `cke`=0 this needs one extra half period after the last clock edge.
- R4: Mode codes 0, 1 and 2 select a master whose serial clock is the system clock divided by 4, 16 and 64. Each half period is therefore 2, 8 or 32 system clocks.
- R5: In master mode, while `sleep` is high, `sck_o` and the shift state hold. After release the byte completes with the correct data.
- R6: In slave mode (code 4 with select gating, code 5 without), bits are shifted on the external `sck_i` edges whether or not `sleep` is high. After 8 bits the byte goes to the buffer and `irq_flag` is set. `wake` is high while both `irq_flag` and `irq_en` are high.
- R7: In code 4, a high `ss_n` drives `sdo_oe` low and clears the bit count. A partly received byte is therefore discarded, and the next selected byte is received whole.
- R8: `buf_full` rises when a byte is placed in the buffer and falls on a `rd_en` pulse.
- R9: A write while a byte is in progress sets `wcol` and does not disturb the byte being shifted.
- R10: A byte that completes while `buf_full` is high sets `ovf`. `rd_data` keeps the earlier byte.
- R11: After reset, or while `en` is low, the port is idle. No byte is in progress, `sck_o` equals `cpol`, `sdo_oe` is low and all flags are clear. Dropping `en` in the middle of a byte aborts it without raising `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| mode | input | 4 | 0/1/2 master div 4/16/64, 4 slave with select, 5 slave without select |
| cpol | input | 1 | Serial clock idle level |
| cke | input | 1 | Edge select, 1 = phase 0 |
| smp | input | 1 | Master sample point, 1 = end of bit |
| irq_en | input | 1 | Lets a set interrupt flag request wake |
| sleep | input | 1 | Freezes master operation |
| wr_en | input | 1 | Write pulse for the data buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read pulse, clears buffer-full |
| rd_data | output | 8 | Last byte received |
| clr_irq | input | 1 | Clears `irq_flag` |
| clr_wcol | input | 1 | Clears `wcol` |
| clr_ovf | input | 1 | Clears `ovf` |
| buf_full | output | 1 | Received byte waiting |
| irq_flag | output | 1 | Byte complete |
| wcol | output | 1 | Write collision |
| ovf | output | 1 | Receive overflow |
| wake | output | 1 | Wake request |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Slave serial clock |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The hardest case to reach from the ports is the sample-point choice. A normally behaving partner returns correct data whichever sample point the master uses.

The bench therefore adds a "late" partner that changes its data half a bit after the usual time. With this partner, the end-of-bit sample gives the byte back intact, while the mid-bit sample gives it shifted by one position.

The extra half period for end-of-bit sampling with `cke`=0 is exercised as well. A second hard case, an aborted slave byte, is produced by raising the select input after three bits. The next byte is then checked to arrive whole.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] mode,
  input  logic       cpol,
  input  logic       cke,
  input  logic       smp,
  input  logic       irq_en,
  input  logic       sleep,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       clr_irq,
  input  logic       clr_wcol,
  input  logic       clr_ovf,
  output logic       buf_full,
  output logic       irq_flag,
  output logic       wcol,
  output logic       ovf,
  output logic       wake,
  output logic       sck_o,
  input  logic       sck_i,
  input  logic       ss_n,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe
);
  logic is_m, is_s, use_ss, cpha;
  logic [4:0] hp_m1, cnt, k;
  logic active, sdo_q, sck_q;
  logic [7:0] sr, rbuf, sr_nx;
  logic [2:0] bitcnt;
  logic [SYNC-1:0] sck_p, sdi_p, ss_p;
  logic sck_d, sck_s, sdi_s, ss_s;
  logic tick, m_samp, m_out, m_last;
  logic s_edge, s_lead, s_samp, s_out, s_gated;
  logic samp, outev, sbit, done, busy;

  assign is_m   = en && (mode == 4'd0 || mode == 4'd1 || mode == 4'd2);
  assign is_s   = en && (mode == 4'd4 || mode == 4'd5);
  assign use_ss = (mode == 4'd4);
  assign cpha   = ~cke;

  always_comb
    case (mode[1:0])
      2'd0:    hp_m1 = 5'd1;
      2'd1:    hp_m1 = 5'd7;
      default: hp_m1 = 5'd31;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; sdi_p <= '0; ss_p <= '1; sck_d <= 1'b0;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sck_i};
      sdi_p <= {sdi_p[SYNC-2:0], sdi};
      ss_p  <= {ss_p[SYNC-2:0], ss_n};
      sck_d <= sck_s;
    end

  assign sck_s = sck_p[SYNC-1];
  assign sdi_s = sdi_p[SYNC-1];
  assign ss_s  = ss_p[SYNC-1];
  assign s_gated = use_ss && ss_s;

  assign tick   = is_m && active && !sleep && cnt == hp_m1;
  assign m_samp = tick && (!smp ? (cpha ? k[0] : !k[0])
                                : (cpha ? (!k[0] && k >= 5'd2) : k[0]));
  assign m_out  = tick && (cpha ? (!k[0] && k < 5'd16) : k[0]);
  assign m_last = tick && (k == ((cpha && smp) ? 5'd16 : 5'd15));

  assign s_edge = is_s && (sck_s != sck_d) && !s_gated;
  assign s_lead = s_edge && (sck_s != cpol);
  assign s_samp = cpha ? (s_edge && !s_lead) : s_lead;
  assign s_out  = cpha ? s_lead : (s_edge && !s_lead);

  assign samp  = m_samp || s_samp;
  assign outev = m_out || s_out;
  assign sbit  = is_m ? sdi : sdi_s;
  assign sr_nx = samp ? {sr[6:0], sbit} : sr;
  assign done  = m_last || (s_samp && bitcnt == 3'd7);
  assign busy  = is_m ? active : (bitcnt != 3'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; k <= '0; sr <= '0; rbuf <= '0;
      sdo_q <= 1'b0; sck_q <= 1'b0; bitcnt <= '0;
      buf_full <= 1'b0; irq_flag <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else if (!en) begin
      active <= 1'b0; cnt <= '0; k <= '0; sr <= '0; rbuf <= '0;
      sdo_q <= 1'b0; sck_q <= cpol; bitcnt <= '0;
      buf_full <= 1'b0; irq_flag <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else begin
      if (clr_irq)  irq_flag <= 1'b0;
      if (clr_wcol) wcol <= 1'b0;
      if (clr_ovf)  ovf <= 1'b0;
      if (!active) sck_q <= cpol;
      if (wr_en) begin
        if (busy) wcol <= 1'b1;
        else begin
          sr <= wr_data;
          sdo_q <= wr_data[7];
          if (is_m) begin active <= 1'b1; k <= '0; cnt <= '0; end
        end
      end
      if (is_m && active && !sleep) cnt <= (cnt == hp_m1) ? 5'd0 : cnt + 5'd1;
      if (tick) begin
        k <= k + 5'd1;
        if (k < 5'd16) sck_q <= ~sck_q;
      end
      if (samp) sr <= sr_nx;
      if (outev) sdo_q <= samp ? sr[6] : sr[7];
      if (s_samp) bitcnt <= bitcnt + 3'd1;
      if (is_s && s_gated) bitcnt <= '0;
      if (done) begin
        irq_flag <= 1'b1;
        if (buf_full && !rd_en) ovf <= 1'b1;
        else begin rbuf <= sr_nx; buf_full <= 1'b1; end
        if (is_m) active <= 1'b0;
      end else if (rd_en) buf_full <= 1'b0;
    end

  assign rd_data = rbuf;
  assign sck_o   = sck_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = is_m || (is_s && !s_gated);
  assign wake    = irq_flag && irq_en;

  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (is_m && !active && !$past(active)) |-> sck_o == cpol);
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (is_m && active && sleep) |=> $stable(sck_o) && $stable(sr));
  assert_ss_clears_R7: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (is_s && s_gated) |=> bitcnt == 3'd0);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (rd_en && !done) |=> !buf_full);
  assert_wcol_R9: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wr_en && busy) |=> wcol);
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (done && buf_full && !rd_en) |=> $stable(rd_data) && ovf);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic clk = 0, rst_n = 0, en = 0;
  logic [3:0] mode = 0;
  logic cpol = 0, cke = 1, smp = 0, irq_en = 0, sleep = 0;
  logic wr_en = 0, rd_en = 0, clr_irq = 0, clr_wcol = 0, clr_ovf = 0;
  logic [7:0] wr_data = 0;
  logic sck_i = 0, ss_n = 1, sdi = 0;
  logic [7:0] rd_data;
  logic buf_full, irq_flag, wcol, ovf, wake, sck_o, sdo, sdo_oe;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_port dut (.clk, .rst_n, .en, .mode, .cpol, .cke, .smp, .irq_en, .sleep,
    .wr_en, .wr_data, .rd_en, .rd_data, .clr_irq, .clr_wcol, .clr_ovf,
    .buf_full, .irq_flag, .wcol, .ovf, .wake, .sck_o, .sck_i, .ss_n, .sdi,
    .sdo, .sdo_oe);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); rd_en = 1; clr_irq = 1; clr_wcol = 1; clr_ovf = 1;
    @(negedge clk); rd_en = 0; clr_irq = 0; clr_wcol = 0; clr_ovf = 0;
  endtask

  task automatic config_port(input logic [3:0] m, input logic p, input logic e, input logic s);
    @(negedge clk); en = 0;
    mode = m; cpol = p; cke = e; smp = s; sck_i = p;
    repeat (6) @(negedge clk);
    en = 1;
    @(negedge clk);
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] st, input bit late,
                        input bit dosleep, input bit dowcol, input logic [7:0] exp_rx,
                        input int exp_hp, input string tg);
    int edges = 0, nl = 0, nt = 0, t1 = 0, hpm = 0, cyc = 0;
    logic prev;
    logic [7:0] cap = 0;
    bit froze = 1, lead;
    sdi = cke ? st[7] : 1'b0;
    @(negedge clk); wr_data = tx; wr_en = 1;
    @(negedge clk); wr_en = 0;
    prev = sck_o;
    while (!irq_flag && cyc < 5000) begin
      @(negedge clk); cyc++; wr_en = 0;
      if (sck_o !== prev) begin
        prev = sck_o; edges++; lead = (sck_o != cpol);
        if (edges == 1) t1 = cyc;
        if (edges == 2) hpm = cyc - t1;
        if (lead) begin
          nl++;
          if (cke) begin
            cap = {cap[6:0], sdo};
            if (late && nl >= 2) sdi = st[8-nl];
          end else sdi = st[8-nl];
        end else begin
          nt++;
          if (cke) begin
            if (!late && nt < 8) sdi = st[7-nt];
          end else cap = {cap[6:0], sdo};
        end
        if (dowcol && edges == 3) begin wr_data = 8'hA5; wr_en = 1; end
        if (dosleep && edges == 5) begin
          sleep = 1;
          repeat (40) begin @(negedge clk); if (sck_o !== prev) froze = 0; end
          sleep = 0;
        end
      end
    end
    if (cyc >= 5000) $display("watchdog expired in %s", tg);
    chk(irq_flag == 1, {tg, " R1 irq"}, irq_flag, 1);
    chk(rd_data == exp_rx, {tg, " R1/R2/R3 rx"}, rd_data, exp_rx);
    chk(cap == tx, {tg, " R1/R2 tx msb first"}, cap, tx);
    chk(edges == 16, {tg, " R1 edges"}, edges, 16);
    chk(hpm == exp_hp, {tg, " R4 half period"}, hpm, exp_hp);
    chk(sck_o == cpol, {tg, " R1 idle level"}, sck_o, cpol);
    if (dosleep) chk(froze, {tg, " R5 frozen"}, froze, 1);
    chk(wcol == dowcol, {tg, " R9 wcol"}, wcol, dowcol);
    chk(buf_full == 1, {tg, " R8 full"}, buf_full, 1);
    pulse_clear();
    chk(buf_full == 0, {tg, " R8 cleared"}, buf_full, 0);
  endtask

  task automatic s_bits(input logic [7:0] mtx, input int nb, output logic [7:0] cap);
    cap = 0;
    for (int i = 0; i < nb; i++) begin
      if (cke) sdi = mtx[7-i];
      repeat (8) @(negedge clk);
      if (cke) cap = {cap[6:0], sdo};
      sck_i = ~sck_i;
      if (!cke) sdi = mtx[7-i];
      repeat (8) @(negedge clk);
      if (!cke) cap = {cap[6:0], sdo};
      sck_i = ~sck_i;
    end
  endtask

  task automatic s_xfer(input logic [7:0] htx, input logic [7:0] mtx,
                        input logic [7:0] exp_rd, input bit exp_ovf, input string tg);
    logic [7:0] cap;
    @(negedge clk); wr_data = htx; wr_en = 1;
    @(negedge clk); wr_en = 0;
    ss_n = 0; repeat (6) @(negedge clk);
    s_bits(mtx, 8, cap);
    repeat (10) @(negedge clk);
    chk(irq_flag == 1, {tg, " R6 irq"}, irq_flag, 1);
    chk(rd_data == exp_rd, {tg, " R6/R10 rd_data"}, rd_data, exp_rd);
    chk(ovf == exp_ovf, {tg, " R10 ovf"}, ovf, exp_ovf);
    if (!exp_ovf) chk(cap == htx, {tg, " R6 sdo"}, cap, htx);
    ss_n = 1; repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] junk;
    int cyc;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(buf_full == 0 && irq_flag == 0 && wcol == 0 && ovf == 0, "R11 reset flags", buf_full, 0);
    chk(sdo_oe == 0, "R11 disabled oe", sdo_oe, 0);
    chk(sck_o == 0, "R11 idle sck", sck_o, 0);

    config_port(4'd0, 0, 1, 0);
    m_xfer(8'hB4, 8'h6D, 0, 0, 0, 8'h6D, 2, "mode0 div4");
    config_port(4'd1, 1, 0, 0);
    m_xfer(8'h3C, 8'h81, 0, 0, 0, 8'h81, 8, "mode3 div16");
    config_port(4'd2, 0, 0, 0);
    m_xfer(8'hE1, 8'h5A, 0, 1, 0, 8'h5A, 32, "mode1 div64 sleep R5");
    config_port(4'd0, 1, 1, 0);
    m_xfer(8'h96, 8'hC3, 0, 0, 1, 8'hC3, 2, "mode2 collision R9");
    config_port(4'd0, 0, 1, 1);
    m_xfer(8'h2B, 8'h9E, 1, 0, 0, 8'h9E, 2, "late smp1 R3");
    config_port(4'd0, 0, 1, 0);
    m_xfer(8'h2B, 8'h9E, 1, 0, 0, {1'b1, 7'h4F}, 2, "late smp0 R3");
    config_port(4'd1, 0, 0, 1);
    m_xfer(8'h71, 8'hA6, 0, 0, 0, 8'hA6, 8, "cke0 smp1 R3");

    config_port(4'd5, 0, 1, 0);
    irq_en = 1; sleep = 1;
    s_xfer(8'hD2, 8'h4B, 8'h4B, 0, "slave sleep R6");
    chk(wake == 1, "R6 wake", wake, 1);
    sleep = 0;
    pulse_clear();
    chk(wake == 0, "R6 wake cleared", wake, 0);
    irq_en = 0;

    s_xfer(8'h11, 8'h3C, 8'h3C, 0, "slave first R10");
    s_xfer(8'h22, 8'hC3, 8'h3C, 1, "slave second R10");
    pulse_clear();

    config_port(4'd4, 0, 0, 0);
    ss_n = 1; repeat (6) @(negedge clk);
    chk(sdo_oe == 0, "R7 deselected oe", sdo_oe, 0);
    ss_n = 0; repeat (6) @(negedge clk);
    chk(sdo_oe == 1, "R7 selected oe", sdo_oe, 1);
    s_bits(8'hF0, 3, junk);
    ss_n = 1; repeat (6) @(negedge clk);
    chk(sdo_oe == 0, "R7 abort oe", sdo_oe, 0);
    chk(irq_flag == 0, "R7 no early irq", irq_flag, 0);
    s_xfer(8'h5E, 8'h69, 8'h69, 0, "slave after abort R7");
    pulse_clear();

    config_port(4'd1, 1, 1, 0);
    @(negedge clk); wr_data = 8'hAA; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (30) @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
    chk(sck_o == 1, "R11 abort sck idle", sck_o, 1);
    chk(irq_flag == 0, "R11 abort no irq", irq_flag, 0);
    en = 1;
    m_xfer(8'h0F, 8'hF0, 0, 0, 0, 8'hF0, 8, "after abort R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule